// File: doc/BRIEF.md
# Inter-processor doorbell interrupt registers

This block lets a host processor and a coprocessor on the same chip signal each other. Each direction has three registers. A write-one-to-set register raises a doorbell. A sticky status register holds the raised doorbells. A write-one-to-clear register lowers them. The host-to-coprocessor direction has four ordinary doorbells and one non-maskable doorbell. The coprocessor-to-host direction has a single doorbell. Every status bit drives a level interrupt line toward the receiving processor.

A typical exchange runs like this. The sender places a command in shared memory and writes 1 to a set bit. The receiver takes the interrupt, does the work and writes 1 to the matching clear bit. The sender polls the status register until the bit drops. Each processor has its own single-cycle register port, and both ports see the same map. The map uses byte offsets with word alignment:

| Offset | Register |
|--------|----------|
| 0x00 | host-to-coprocessor status |
| 0x04 | host-to-coprocessor set |
| 0x08 | host-to-coprocessor clear |
| 0x0C | coprocessor-to-host status |
| 0x10 | coprocessor-to-host set |
| 0x14 | coprocessor-to-host clear |

In the host-to-coprocessor registers, bits 0 to 3 are the ordinary doorbells and bit 4 is the non-maskable one. In the coprocessor-to-host registers, only bit 0 is used.

Top module: `ipc_doorbell_regs`

## Requirements
- R1: While reset is asserted and after it is released, both status registers read 0 and every interrupt output is low.
- R2: A write of 1 to bit n of offset 0x04 sets status bit n at offset 0x00 from the next clock edge. Bits 0..3 drive `cop_irq_o[0..3]` in that bit order, and bit 4 drives `cop_nmi_o`.
- R3: A write of 1 to bit 0 of offset 0x10 sets bit 0 of offset 0x0C and raises `host_irq_o` from the next clock edge.
- R4: The set registers at offsets 0x04 and 0x10 always read as 0, on either port.
- R5: A status bit stays at 1 until a 1 is written to the matching bit of its clear register (offset 0x08 or 0x14). That write drops it from the next clock edge.
- R6: Writing 0 to any bit of a set or clear register leaves the status unchanged.
- R7: If one port sets a bit and the other port clears the same bit in the same cycle, the bit ends at 1.
- R8: Each interrupt output is a level equal to its status bit, and either port can read both status registers.
- R9: Register bits above the defined ones read as 0 and ignore writes. Unmapped or misaligned offsets read as 0 and ignore writes. Writes to the status offsets are ignored.
- R10: A write changes only the register it addresses, and only the bits written as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_wr_i | input | 1 | Host port write strobe |
| hst_addr_i | input | 5 | Host port byte offset, used for reads and writes |
| hst_wdata_i | input | 32 | Host port write data |
| hst_rdata_o | output | 32 | Host port read data, combinational from the offset |
| cop_wr_i | input | 1 | Coprocessor port write strobe |
| cop_addr_i | input | 5 | Coprocessor port byte offset |
| cop_wdata_i | input | 32 | Coprocessor port write data |
| cop_rdata_o | output | 32 | Coprocessor port read data, combinational from the offset |
| cop_irq_o | output | 4 | Ordinary doorbell levels toward the coprocessor |
| cop_nmi_o | output | 1 | Non-maskable doorbell level toward the coprocessor |
| host_irq_o | output | 1 | Doorbell level toward the host |

## Verification
The state of this block is its status flops, and each one is visible at two places on the ports: on an interrupt pin and in a status readback. A wrong bit therefore shows on a pin one clock edge after the write that caused it, and it shows in the read data in that same cycle. The bench checks both after every write. It also checks a bit that is stuck, lost or leaking into a neighbour, because every step compares the whole status word. Same-cycle collisions between the two ports are driven on purpose, since a wrong priority shows only in that one cycle.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int H2C_DB = 4;
  localparam int H2C_W  = H2C_DB + 1;
  localparam int C2H_W  = 1;
  localparam int NPORT  = 2;

  typedef enum logic [2:0] {
    SEL_H2C_STAT = 3'd0,
    SEL_H2C_SET  = 3'd1,
    SEL_H2C_CLR  = 3'd2,
    SEL_C2H_STAT = 3'd3,
    SEL_C2H_SET  = 3'd4,
    SEL_C2H_CLR  = 3'd5,
    SEL_NONE     = 3'd7
  } reg_sel_e;

  // Word-aligned decode; anything else selects nothing.
  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] off);
    reg_sel_e sel;
    if (off[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else begin
      case (off[ADDR_W-1:2])
        3'd0:    sel = SEL_H2C_STAT;
        3'd1:    sel = SEL_H2C_SET;
        3'd2:    sel = SEL_H2C_CLR;
        3'd3:    sel = SEL_C2H_STAT;
        3'd4:    sel = SEL_C2H_SET;
        3'd5:    sel = SEL_C2H_CLR;
        default: sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

  // Sticky status update: clear first, then set, so a set wins a collision.
  function automatic logic [DATA_W-1:0] db_next(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] set_m,
                                                input logic [DATA_W-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

endpackage

// File: rtl/ipc_reg_port.sv
module ipc_reg_port
  import ipc_db_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_H2C_W  = H2C_W,
  parameter int P_C2H_W  = C2H_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic [P_DATA_W-1:0] wdata_i,
  input  logic [P_H2C_W-1:0]  h2c_stat_i,
  input  logic [P_C2H_W-1:0]  c2h_stat_i,
  output logic [P_H2C_W-1:0]  h2c_set_o,
  output logic [P_H2C_W-1:0]  h2c_clr_o,
  output logic [P_C2H_W-1:0]  c2h_set_o,
  output logic [P_C2H_W-1:0]  c2h_clr_o,
  output logic [P_DATA_W-1:0] rdata_o
);

  reg_sel_e sel;

  // Decode events, named so the checks below can see them.
  logic hit_h2c_set, hit_h2c_clr, hit_c2h_set, hit_c2h_clr;

  always_comb begin
    sel         = decode_offset(ADDR_W'(addr_i));
    hit_h2c_set = wr_i && (sel == SEL_H2C_SET);
    hit_h2c_clr = wr_i && (sel == SEL_H2C_CLR);
    hit_c2h_set = wr_i && (sel == SEL_C2H_SET);
    hit_c2h_clr = wr_i && (sel == SEL_C2H_CLR);
  end

  assign h2c_set_o = hit_h2c_set ? wdata_i[P_H2C_W-1:0] : '0;
  assign h2c_clr_o = hit_h2c_clr ? wdata_i[P_H2C_W-1:0] : '0;
  assign c2h_set_o = hit_c2h_set ? wdata_i[P_C2H_W-1:0] : '0;
  assign c2h_clr_o = hit_c2h_clr ? wdata_i[P_C2H_W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_H2C_STAT: rdata_o[P_H2C_W-1:0] = h2c_stat_i;
      SEL_C2H_STAT: rdata_o[P_C2H_W-1:0] = c2h_stat_i;
      default:      rdata_o = '0;
    endcase
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|h2c_set_o, |h2c_clr_o, |c2h_set_o, |c2h_clr_o})) // R10
    else $error("write strobed more than one register");

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |-> !(|{h2c_set_o, h2c_clr_o, c2h_set_o, c2h_clr_o})) // R6
    else $error("strobe without write");

endmodule

// File: rtl/ipc_doorbell_bank.sv
module ipc_doorbell_bank
  import ipc_db_pkg::*;
#(
  parameter int W       = H2C_W,
  parameter int P_NPORT = NPORT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [P_NPORT*W-1:0] set_i,
  input  logic [P_NPORT*W-1:0] clr_i,
  output logic [W-1:0]         status_o
);

  logic [W-1:0] set_any, clr_any, status_d, status_q;

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < P_NPORT; p++) begin
      set_any |= set_i[p*W +: W];
      clr_any |= clr_i[p*W +: W];
    end
    status_d = W'(db_next(DATA_W'(status_q), DATA_W'(set_any), DATA_W'(clr_any)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0)) // R1
    else $error("status not cleared by reset");

  for (genvar b = 0; b < W; b++) begin : g_bit
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_any[b] |=> status_q[b]) // R7
      else $error("set lost on bit %0d", b);

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_any[b] && !set_any[b]) |=> !status_q[b]) // R5
      else $error("clear ignored on bit %0d", b);

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_any[b] && !clr_any[b]) |=> $stable(status_q[b])) // R5
      else $error("bit %0d changed without a write", b);
  end

endmodule

// File: rtl/ipc_doorbell_regs.sv
module ipc_doorbell_regs
  import ipc_db_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_H2C_DB = H2C_DB,
  parameter int P_C2H_W  = C2H_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_wr_i,
  input  logic [P_ADDR_W-1:0] hst_addr_i,
  input  logic [P_DATA_W-1:0] hst_wdata_i,
  output logic [P_DATA_W-1:0] hst_rdata_o,
  input  logic                cop_wr_i,
  input  logic [P_ADDR_W-1:0] cop_addr_i,
  input  logic [P_DATA_W-1:0] cop_wdata_i,
  output logic [P_DATA_W-1:0] cop_rdata_o,
  output logic [P_H2C_DB-1:0] cop_irq_o,
  output logic                cop_nmi_o,
  output logic [P_C2H_W-1:0]  host_irq_o
);

  localparam int LH2C_W = P_H2C_DB + 1;
  localparam int NMI_B  = P_H2C_DB;

  logic [NPORT-1:0]          wr_v;
  logic [NPORT*P_ADDR_W-1:0] addr_v;
  logic [NPORT*P_DATA_W-1:0] wdata_v, rdata_v;
  logic [NPORT*LH2C_W-1:0]   h2c_set_v, h2c_clr_v;
  logic [NPORT*P_C2H_W-1:0]  c2h_set_v, c2h_clr_v;
  logic [LH2C_W-1:0]         h2c_stat;
  logic [P_C2H_W-1:0]        c2h_stat;

  // Port 0 is the host side, port 1 the coprocessor side.
  assign wr_v    = {cop_wr_i, hst_wr_i};
  assign addr_v  = {cop_addr_i, hst_addr_i};
  assign wdata_v = {cop_wdata_i, hst_wdata_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ipc_reg_port #(
      .P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W),
      .P_H2C_W (LH2C_W),   .P_C2H_W (P_C2H_W)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_v[p]),
      .addr_i    (addr_v[p*P_ADDR_W +: P_ADDR_W]),
      .wdata_i   (wdata_v[p*P_DATA_W +: P_DATA_W]),
      .h2c_stat_i(h2c_stat),
      .c2h_stat_i(c2h_stat),
      .h2c_set_o (h2c_set_v[p*LH2C_W +: LH2C_W]),
      .h2c_clr_o (h2c_clr_v[p*LH2C_W +: LH2C_W]),
      .c2h_set_o (c2h_set_v[p*P_C2H_W +: P_C2H_W]),
      .c2h_clr_o (c2h_clr_v[p*P_C2H_W +: P_C2H_W]),
      .rdata_o   (rdata_v[p*P_DATA_W +: P_DATA_W])
    );
  end

  ipc_doorbell_bank #(.W(LH2C_W), .P_NPORT(NPORT)) u_h2c (
    .clk(clk), .rst_n(rst_n),
    .set_i(h2c_set_v), .clr_i(h2c_clr_v), .status_o(h2c_stat)
  );

  ipc_doorbell_bank #(.W(P_C2H_W), .P_NPORT(NPORT)) u_c2h (
    .clk(clk), .rst_n(rst_n),
    .set_i(c2h_set_v), .clr_i(c2h_clr_v), .status_o(c2h_stat)
  );

  assign hst_rdata_o = rdata_v[0 +: P_DATA_W];
  assign cop_rdata_o = rdata_v[P_DATA_W +: P_DATA_W];
  assign cop_irq_o   = h2c_stat[P_H2C_DB-1:0];
  assign cop_nmi_o   = h2c_stat[NMI_B];
  assign host_irq_o  = c2h_stat;

  AST_NMI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr_i && hst_addr_i == P_ADDR_W'(4) && hst_wdata_i[NMI_B]) |=> cop_nmi_o) // R2
    else $error("non-maskable doorbell not raised");

  AST_HOST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_wr_i && cop_addr_i == P_ADDR_W'(16) && cop_wdata_i[0]) |=> host_irq_o[0]) // R3
    else $error("host doorbell not raised");

  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_addr_i == P_ADDR_W'(4) || hst_addr_i == P_ADDR_W'(16)) |-> (hst_rdata_o == '0)) // R4
    else $error("set register read nonzero");

endmodule

// File: tb/ipc_doorbell_regs_tb.sv
module ipc_doorbell_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0, cop_wr = 1'b0;
  logic [4:0]  hst_addr = '0, cop_addr = '0;
  logic [31:0] hst_wdata = '0, cop_wdata = '0;
  logic [31:0] hst_rdata, cop_rdata;
  logic [3:0]  cop_irq;
  logic        cop_nmi;
  logic [0:0]  host_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ipc_doorbell_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .hst_wr_i(hst_wr), .hst_addr_i(hst_addr), .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata),
    .cop_wr_i(cop_wr), .cop_addr_i(cop_addr), .cop_wdata_i(cop_wdata), .cop_rdata_o(cop_rdata),
    .cop_irq_o(cop_irq), .cop_nmi_o(cop_nmi), .host_irq_o(host_irq)
  );

  // port: 0 host, 1 coprocessor; exp_h2c bits 3..0 ordinary, bit 4 NMI
  typedef struct packed {
    logic        port;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [4:0]  exp_h2c;
    logic        exp_c2h;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h04, 32'h0000_0001, 5'h01, 1'b0, 4'd2},
    '{1'b0, 5'h04, 32'h0000_0010, 5'h11, 1'b0, 4'd2},
    '{1'b1, 5'h04, 32'h0000_000A, 5'h1B, 1'b0, 4'd10},
    '{1'b0, 5'h04, 32'h0000_0000, 5'h1B, 1'b0, 4'd6},
    '{1'b1, 5'h08, 32'h0000_0001, 5'h1A, 1'b0, 4'd5},
    '{1'b1, 5'h08, 32'h0000_0000, 5'h1A, 1'b0, 4'd6},
    '{1'b1, 5'h10, 32'h0000_0001, 5'h1A, 1'b1, 4'd3},
    '{1'b0, 5'h08, 32'hFFFF_FFE0, 5'h1A, 1'b1, 4'd9},
    '{1'b0, 5'h14, 32'h0000_0001, 5'h1A, 1'b0, 4'd5},
    '{1'b0, 5'h18, 32'hFFFF_FFFF, 5'h1A, 1'b0, 4'd9},
    '{1'b1, 5'h08, 32'h0000_001F, 5'h00, 1'b0, 4'd5},
    '{1'b0, 5'h10, 32'h0000_0001, 5'h00, 1'b1, 4'd3},
    '{1'b0, 5'h00, 32'h0000_001F, 5'h00, 1'b1, 4'd9},
    '{1'b1, 5'h14, 32'h0000_0001, 5'h00, 1'b0, 4'd5}
  };

  function automatic string rtag(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write1(input logic port, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    if (port) begin cop_wr = 1'b1; cop_addr = a; cop_wdata = d; end
    else      begin hst_wr = 1'b1; hst_addr = a; hst_wdata = d; end
    @(negedge clk);
    hst_wr = 1'b0; cop_wr = 1'b0;
  endtask

  // Read status on both ports and compare status, pins and readback together.
  task automatic observe(input string tag, input logic [4:0] eh, input logic ec);
    hst_addr = 5'h00; cop_addr = 5'h0C;
    #1;
    check({tag, " status h2c"}, hst_rdata, {27'd0, eh});
    check({tag, " status c2h"}, cop_rdata, {31'd0, ec});
    check({tag, " pins"}, {26'd0, cop_nmi, cop_irq, host_irq}, {26'd0, eh, ec});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    observe("R1 in reset", 5'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    observe("R1 after reset", 5'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      write1(VECS[i].port, VECS[i].addr, VECS[i].wdata);
      observe($sformatf("%s vec%0d", rtag(VECS[i].req), i), VECS[i].exp_h2c, VECS[i].exp_c2h);
    end

    // R2: each ordinary bit lands on its own line, in order
    for (int b = 0; b < 4; b++) begin
      write1(1'b0, 5'h04, 32'(1) << b);
      observe($sformatf("R2 bit%0d", b), 5'(1 << b), 1'b0);
      write1(1'b1, 5'h08, 32'(1) << b);
    end

    // R4: set registers read zero with bits pending, on both ports
    write1(1'b0, 5'h04, 32'h1F);
    write1(1'b1, 5'h10, 32'h1);
    hst_addr = 5'h04; cop_addr = 5'h10; #1;
    check("R4 host reads h2c set", hst_rdata, 32'h0);
    check("R4 cop reads c2h set", cop_rdata, 32'h0);
    hst_addr = 5'h10; cop_addr = 5'h04; #1;
    check("R4 host reads c2h set", hst_rdata, 32'h0);
    check("R4 cop reads h2c set", cop_rdata, 32'h0);

    // R9: unmapped and misaligned offsets read zero
    hst_addr = 5'h1C; cop_addr = 5'h01; #1;
    check("R9 unmapped read", hst_rdata, 32'h0);
    check("R9 misaligned read", cop_rdata, 32'h0);

    // R8: status visible from the other port too
    hst_addr = 5'h0C; cop_addr = 5'h00; #1;
    check("R8 host reads c2h", hst_rdata, 32'h1);
    check("R8 cop reads h2c", cop_rdata, 32'h1F);

    // R5: sticky over idle cycles
    repeat (20) @(negedge clk);
    observe("R5 held", 5'h1F, 1'b1);

    // R7: collisions, set from one port and clear from the other
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = 5'h04; hst_wdata = 32'h4;
    cop_wr = 1'b1; cop_addr = 5'h08; cop_wdata = 32'h6;
    @(negedge clk);
    hst_wr = 1'b0; cop_wr = 1'b0;
    observe("R7 h2c collide", 5'h1D, 1'b1);

    write1(1'b0, 5'h14, 32'h1);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = 5'h14; hst_wdata = 32'h1;
    cop_wr = 1'b1; cop_addr = 5'h10; cop_wdata = 32'h1;
    @(negedge clk);
    hst_wr = 1'b0; cop_wr = 1'b0;
    observe("R7 c2h collide", 5'h1D, 1'b1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    observe("R1 reset again", 5'h00, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule